// File: doc/BRIEF.md
# DMA Transfer Count Register Block

This block holds the byte count for a DMA transfer. The count is 24 bits wide. Software sees it as three byte registers on a byte-wide register bus, with the low byte at the lowest address. Software writes the count it wants to transfer into a start copy. Reads of the same three addresses return the live count, which is a separate register. The live count changes in only two ways. A command write whose DMA flag is set loads the live count from the start copy. Each byte moved through the pseudo-DMA port takes one off the live count.

The block raises a terminal-count flag when the live count runs out. A write to any of the three count registers clears the flag. Until software first writes the high count register, reading that address returns a fixed chip identifier instead of the count.

The block also holds the last command byte and a configuration register. Its outputs are the live count, the terminal-count flag and the DMA-mode bit, which a neighbouring bus-phase engine uses.

Top module: `xfer_count_regs`

## Requirements
- R1: After reset, the live count is 0, the terminal-count flag and DMA mode are 0, the status register (address 4) reads 0, and the configuration register (address 5) reads 7.
- R2: Writes to the count registers (address 0 = low, 1 = middle, 2 = high) go to the start copy only. They leave the live count, read back at the same addresses, unchanged.
- R3: A write to the command register (address 3) with bit 7 set loads the live count from the start copy and sets DMA mode. DMA mode reads back as status bit 1.
- R4: A DMA-flagged command with a start count of zero loads the live count with 0x010000.
- R5: A command write with bit 7 clear clears DMA mode and leaves the live count unchanged.
- R6: Each cycle with a pseudo-DMA byte strobe takes one off a nonzero live count.
- R7: A pseudo-DMA strobe that arrives while the live count is zero is discarded. The count stays 0 and the terminal-count flag keeps its value.
- R8: The terminal-count flag (status bit 0) is set on the edge where a strobe takes the live count from 1 to 0.
- R9: A write to any count register clears the terminal-count flag.
- R10: Address 2 reads the chip identifier until address 2 has been written once since reset. After that write it reads the live high byte. Reset makes it read the identifier again.
- R11: When a DMA-flagged command and a pseudo-DMA strobe fall in the same cycle, the reload wins and no byte is counted.
- R12: When a count-register write and a strobe that takes the count from 1 to 0 fall in the same cycle, the terminal-count flag ends up set.
- R13: The configuration register holds the last byte written to it. The command register (address 3) reads back the last command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pdma_wr | input | 1 | One byte moved through the pseudo-DMA port |
| xfer_count | output | COUNT_W | Live transfer count |
| tc_flag | output | 1 | Terminal-count flag |
| dma_mode | output | 1 | DMA mode set by the last command |

## Verification
The live count has two writers: the command reload and the pseudo-DMA decrement. The bench fires a DMA-flagged command and a byte strobe in the same cycle. It judges the result by reading the three count bytes: the live count must equal the start count, not the start count minus one.

The terminal-count flag also has two writers: a count-register write clears it and a final decrement sets it. The bench lines the count up at 1 and issues both in one cycle. It then expects status bit 0 to be set.

// File: rtl/xfer_count_pkg.sv
package xfer_count_pkg;
    localparam int BYTE_W       = 8;
    localparam int CMD_DMA_BIT  = 7;
    localparam int STAT_TC_BIT  = 0;
    localparam int STAT_DMA_BIT = 1;
endpackage

// File: rtl/xfer_count_decode.sv
// Turns a bus write into one-hot strobes for the write-side registers.
module xfer_count_decode #(
    parameter int NBYTES  = 3,
    parameter int ADDR_W  = 4,
    parameter int ADR_CMD = 3,
    parameter int ADR_CFG = 5
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              dma_flag,
    output logic [NBYTES-1:0] cnt_wr,
    output logic              cmd_wr,
    output logic              cmd_dma,
    output logic              cfg_wr
);
    for (genvar k = 0; k < NBYTES; k++) begin : g_cnt
        assign cnt_wr[k] = reg_wr && (reg_addr == ADDR_W'(k));
    end

    assign cmd_wr  = reg_wr && (reg_addr == ADDR_W'(ADR_CMD));
    assign cmd_dma = cmd_wr && dma_flag;
    assign cfg_wr  = reg_wr && (reg_addr == ADDR_W'(ADR_CFG));
endmodule

// File: rtl/xfer_count_wregs.sv
// Write-side registers: start count, written-once flag, command, config.
module xfer_count_wregs #(
    parameter int             NBYTES    = 3,
    parameter logic [7:0]     CFG_RESET = 8'h07
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NBYTES-1:0]             cnt_wr,
    input  logic                          cmd_wr,
    input  logic                          cfg_wr,
    input  logic [7:0]                    wdata,
    output logic [NBYTES*8-1:0]           start_cnt,
    output logic                          hi_written,
    output logic [7:0]                    cmd_byte,
    output logic [7:0]                    cfg_byte
);
    typedef struct packed {
        logic [NBYTES-1:0][7:0] start;
        logic                   hi_wr;
        logic [7:0]             cmd;
        logic [7:0]             cfg;
    } wside_t;

    wside_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int k = 0; k < NBYTES; k++) begin
            if (cnt_wr[k]) begin
                s_d.start[k] = wdata;
            end
        end
        if (cnt_wr[NBYTES-1]) begin
            s_d.hi_wr = 1'b1;
        end
        if (cmd_wr) begin
            s_d.cmd = wdata;
        end
        if (cfg_wr) begin
            s_d.cfg = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.cfg   <= CFG_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign start_cnt  = s_q.start;
    assign hi_written = s_q.hi_wr;
    assign cmd_byte   = s_q.cmd;
    assign cfg_byte   = s_q.cfg;
endmodule

// File: rtl/xfer_count_engine.sv
// Live count: reload on a DMA command, decrement per pseudo-DMA byte.
module xfer_count_engine #(
    parameter int COUNT_W    = 24,
    parameter int ZERO_SHIFT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic               cmd_dma,
    input  logic               any_cnt_wr,
    input  logic               pdma_wr,
    input  logic [COUNT_W-1:0] start_cnt,
    output logic [COUNT_W-1:0] live_cnt,
    output logic               tc,
    output logic               dma_on
);
    localparam logic [COUNT_W-1:0] ZERO_VAL = COUNT_W'(1) << ZERO_SHIFT;

    typedef struct packed {
        logic [COUNT_W-1:0] live;
        logic               tc;
        logic               dma;
    } eng_t;

    eng_t e_d, e_q;
    logic cnt_zero;
    logic cnt_one;

    assign cnt_zero = (e_q.live == '0);
    assign cnt_one  = (e_q.live == COUNT_W'(1));

    always_comb begin
        e_d = e_q;
        if (any_cnt_wr) begin
            e_d.tc = 1'b0;
        end
        if (cmd_wr) begin
            e_d.dma = cmd_dma;
            if (cmd_dma) begin
                e_d.live = (start_cnt == '0) ? ZERO_VAL : start_cnt;
            end
        end else if (pdma_wr && !cnt_zero) begin
            e_d.live = e_q.live - COUNT_W'(1);
            if (cnt_one) begin
                e_d.tc = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign live_cnt = e_q.live;
    assign tc       = e_q.tc;
    assign dma_on   = e_q.dma;
endmodule

// File: rtl/xfer_count_rdmux.sv
// Read data selection.
module xfer_count_rdmux #(
    parameter int         NBYTES   = 3,
    parameter int         ADDR_W   = 4,
    parameter int         ADR_CMD  = 3,
    parameter int         ADR_STAT = 4,
    parameter int         ADR_CFG  = 5,
    parameter logic [7:0] CHIP_ID  = 8'hA2
) (
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [NBYTES*8-1:0]   live_cnt,
    input  logic                  hi_written,
    input  logic                  tc,
    input  logic                  dma_on,
    input  logic [7:0]            cmd_byte,
    input  logic [7:0]            cfg_byte,
    output logic [7:0]            rdata
);
    import xfer_count_pkg::*;

    logic [7:0] status;

    always_comb begin
        status               = '0;
        status[STAT_TC_BIT]  = tc;
        status[STAT_DMA_BIT] = dma_on;
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NBYTES; k++) begin
            if (reg_addr == ADDR_W'(k)) begin
                rdata = live_cnt[k*8 +: 8];
            end
        end
        if (reg_addr == ADDR_W'(NBYTES-1) && !hi_written) begin
            rdata = CHIP_ID;
        end
        if (reg_addr == ADDR_W'(ADR_CMD))  rdata = cmd_byte;
        if (reg_addr == ADDR_W'(ADR_STAT)) rdata = status;
        if (reg_addr == ADDR_W'(ADR_CFG))  rdata = cfg_byte;
    end
endmodule

// File: rtl/xfer_count_regs.sv
module xfer_count_regs #(
    parameter int         COUNT_W    = 24,
    parameter int         ADDR_W     = 4,
    parameter int         ZERO_SHIFT = 16,
    parameter logic [7:0] CHIP_ID    = 8'hA2,
    parameter logic [7:0] CFG_RESET  = 8'h07
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               pdma_wr,
    output logic [COUNT_W-1:0] xfer_count,
    output logic               tc_flag,
    output logic               dma_mode
);
    import xfer_count_pkg::*;

    localparam int NBYTES   = COUNT_W / BYTE_W;
    localparam int ADR_CMD  = NBYTES;
    localparam int ADR_STAT = NBYTES + 1;
    localparam int ADR_CFG  = NBYTES + 2;

    logic [NBYTES-1:0]  cnt_wr;
    logic               cmd_wr;
    logic               cmd_dma;
    logic               cfg_wr;
    logic [COUNT_W-1:0] start_cnt;
    logic               hi_written;
    logic [7:0]         cmd_byte;
    logic [7:0]         cfg_byte;

    xfer_count_decode #(
        .NBYTES(NBYTES), .ADDR_W(ADDR_W), .ADR_CMD(ADR_CMD), .ADR_CFG(ADR_CFG)
    ) u_dec (
        .reg_wr  (reg_wr),
        .reg_addr(reg_addr),
        .dma_flag(reg_wdata[CMD_DMA_BIT]),
        .cnt_wr  (cnt_wr),
        .cmd_wr  (cmd_wr),
        .cmd_dma (cmd_dma),
        .cfg_wr  (cfg_wr)
    );

    xfer_count_wregs #(
        .NBYTES(NBYTES), .CFG_RESET(CFG_RESET)
    ) u_wregs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_wr    (cnt_wr),
        .cmd_wr    (cmd_wr),
        .cfg_wr    (cfg_wr),
        .wdata     (reg_wdata),
        .start_cnt (start_cnt),
        .hi_written(hi_written),
        .cmd_byte  (cmd_byte),
        .cfg_byte  (cfg_byte)
    );

    xfer_count_engine #(
        .COUNT_W(COUNT_W), .ZERO_SHIFT(ZERO_SHIFT)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_dma   (cmd_dma),
        .any_cnt_wr(|cnt_wr),
        .pdma_wr   (pdma_wr),
        .start_cnt (start_cnt),
        .live_cnt  (xfer_count),
        .tc        (tc_flag),
        .dma_on    (dma_mode)
    );

    xfer_count_rdmux #(
        .NBYTES(NBYTES), .ADDR_W(ADDR_W), .ADR_CMD(ADR_CMD),
        .ADR_STAT(ADR_STAT), .ADR_CFG(ADR_CFG), .CHIP_ID(CHIP_ID)
    ) u_rd (
        .reg_addr  (reg_addr),
        .live_cnt  (xfer_count),
        .hi_written(hi_written),
        .tc        (tc_flag),
        .dma_on    (dma_mode),
        .cmd_byte  (cmd_byte),
        .cfg_byte  (cfg_byte),
        .rdata     (reg_rdata)
    );
endmodule

// File: rtl/xfer_count_chk.sv
module xfer_count_chk #(
    parameter int COUNT_W = 24,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               dma_flag,
    input logic               pdma_wr,
    input logic [COUNT_W-1:0] xfer_count,
    input logic               tc_flag,
    input logic               dma_mode
);
    localparam int NBYTES = COUNT_W / 8;

    logic cmd_w, cnt_w, last_dec;
    assign cmd_w    = reg_wr && (reg_addr == ADDR_W'(NBYTES));
    assign cnt_w    = reg_wr && (reg_addr < ADDR_W'(NBYTES));
    assign last_dec = pdma_wr && !cmd_w && (xfer_count == COUNT_W'(1));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_w && !pdma_wr) |=> $stable(xfer_count));
    a_r3_dma_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && dma_flag) |=> dma_mode);
    a_r5_nodma: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && !dma_flag) |=> (!dma_mode && $stable(xfer_count)));
    a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (pdma_wr && !cmd_w && xfer_count != '0) |=> (xfer_count == $past(xfer_count) - COUNT_W'(1)));
    a_r7_zero_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (pdma_wr && !cmd_w && !cnt_w && xfer_count == '0) |=> (xfer_count == '0 && $stable(tc_flag)));
    a_r8_tc_set: assert property (@(posedge clk) disable iff (!rst_n)
        last_dec |=> tc_flag);
    a_r9_tc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_w && !last_dec) |=> !tc_flag);
endmodule

bind xfer_count_regs xfer_count_chk #(.COUNT_W(COUNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .dma_flag  (reg_wdata[7]),
    .pdma_wr   (pdma_wr),
    .xfer_count(xfer_count),
    .tc_flag   (tc_flag),
    .dma_mode  (dma_mode)
);

// File: tb/tb_xfer_count_regs.sv
`timescale 1ns/1ps
module tb_xfer_count_regs;
    localparam logic [7:0] ID = 8'hA2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       pdma_wr = 1'b0;
    logic [23:0] xfer_count;
    logic       tc_flag;
    logic       dma_mode;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    xfer_count_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pdma_wr(pdma_wr),
        .xfer_count(xfer_count), .tc_flag(tc_flag), .dma_mode(dma_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, return at the following negedge.
    task automatic cyc(input logic w, input logic [3:0] a, input logic [7:0] d, input logic p);
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d; pdma_wr = p;
        @(negedge clk);
        reg_wr = 1'b0; pdma_wr = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rd_cnt(output logic [23:0] c);
        logic [7:0] b0, b1, b2;
        rd(4'd0, b0); rd(4'd1, b1); rd(4'd2, b2);
        c = {b2, b1, b0};
    endtask

    task automatic set_start(input logic [23:0] v);
        wr(4'd0, v[7:0]); wr(4'd1, v[15:8]); wr(4'd2, v[23:16]);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(4'd0, v); chk("R1 count low", v, 8'h00);
        rd(4'd1, v); chk("R1 count mid", v, 8'h00);
        rd(4'd2, v); chk("R10 id before write", v, ID);
        rd(4'd4, v); chk("R1 status", v, 8'h00);
        rd(4'd5, v); chk("R1 config", v, 8'h07);
    endtask

    task automatic t_hold_and_id;
        logic [7:0] v;
        wr(4'd0, 8'h34); wr(4'd1, 8'h12);
        rd(4'd0, v); chk("R2 low unchanged", v, 8'h00);
        rd(4'd1, v); chk("R2 mid unchanged", v, 8'h00);
        rd(4'd2, v); chk("R10 id still before hi write", v, ID);
        wr(4'd2, 8'h00);
        rd(4'd2, v); chk("R10 live hi after write", v, 8'h00);
    endtask

    task automatic t_reload;
        logic [23:0] c; logic [7:0] v;
        wr(4'd3, 8'h90);
        rd_cnt(c); chk("R3 reload value", c, 24'h001234);
        rd(4'd4, v); chk("R3 dma mode bit", v, 8'h02);
        rd(4'd3, v); chk("R13 command readback", v, 8'h90);
    endtask

    task automatic t_decrement;
        logic [23:0] c; logic [7:0] v;
        set_start(24'h000003);
        wr(4'd3, 8'h80);
        cyc(1'b0, 4'd0, 8'h00, 1'b1);
        rd_cnt(c); chk("R6 first byte", c, 24'h000002);
        rd(4'd4, v); chk("R8 no tc early", v, 8'h02);
        cyc(1'b0, 4'd0, 8'h00, 1'b1);
        cyc(1'b0, 4'd0, 8'h00, 1'b1);
        rd_cnt(c); chk("R6 third byte", c, 24'h000000);
        rd(4'd4, v); chk("R8 tc set at zero", v, 8'h03);
        cyc(1'b0, 4'd0, 8'h00, 1'b1);
        rd_cnt(c); chk("R7 discard at zero", c, 24'h000000);
        rd(4'd4, v); chk("R7 tc kept", v, 8'h03);
        wr(4'd1, 8'h00);
        rd(4'd4, v); chk("R9 tc cleared by count write", v, 8'h02);
    endtask

    task automatic t_zero_and_nodma;
        logic [23:0] c; logic [7:0] v;
        set_start(24'h000000);
        wr(4'd3, 8'h80);
        rd_cnt(c); chk("R4 zero reloads 0x10000", c, 24'h010000);
        wr(4'd0, 8'h05);
        wr(4'd3, 8'h01);
        rd_cnt(c); chk("R5 count unchanged", c, 24'h010000);
        rd(4'd4, v); chk("R5 dma mode cleared", v, 8'h00);
    endtask

    task automatic t_races;
        logic [23:0] c; logic [7:0] v;
        set_start(24'h000001);
        wr(4'd3, 8'h80);
        cyc(1'b1, 4'd1, 8'h00, 1'b1);
        rd_cnt(c); chk("R12 count reached zero", c, 24'h000000);
        rd(4'd4, v); chk("R12 tc set wins", v, 8'h03);
        set_start(24'h000020);
        cyc(1'b1, 4'd3, 8'h80, 1'b1);
        rd_cnt(c); chk("R11 reload wins", c, 24'h000020);
    endtask

    task automatic t_cfg_and_rereset;
        logic [7:0] v;
        wr(4'd5, 8'h5A);
        rd(4'd5, v); chk("R13 config holds", v, 8'h5A);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(4'd2, v); chk("R10 id after reset", v, ID);
        rd(4'd5, v); chk("R1 config after reset", v, 8'h07);
        rd(4'd0, v); chk("R1 count low after reset", v, 8'h00);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: run hung");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hold_and_id();
        t_reload();
        t_decrement();
        t_zero_and_nodma();
        t_races();
        t_cfg_and_rereset();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule